// File: doc/BRIEF.md
# Radix-4 Butterfly over the Integers Modulo 16417

This block performs one radix-4 butterfly of a number theoretic transform whose arithmetic is carried out in the prime field of order 16417. Four residues enter together: the samples a quarter of a transform length apart, called here `x0` (offset 0), `x1` (offset N/4), `x2` (offset N/2) and `x3` (offset 3N/4). The block returns the four radix-4 combinations of them. The field element J = 3846 squares to 16416, which is -1 mod 16417. It therefore takes the place that the imaginary unit holds in a complex butterfly.

The block has no twiddle stage and no reordering. It is one arithmetic node of a pipelined transform, with one register stage. A sample set is presented with `in_valid` high. Its results appear one clock later with `out_valid` high. The outputs hold their last values whenever `in_valid` is low. Inputs are 16 bits wide, and any input of 16417 or above is taken as its residue.

Top module: `ntt_radix4_butterfly`

## Requirements
- R1: `y0` equals (x0 + x1 + x2 + x3) mod 16417.
- R2: `y1` equals (x0 - J*x1 - x2 + J*x3) mod 16417, with J = 3846.
- R3: `y2` equals (x0 - x1 + x2 - x3) mod 16417.
- R4: `y3` equals (x0 + J*x1 - x2 - J*x3) mod 16417, with J = 3846.
- R5: The constant J is 3846, so x1 = 1 with all other inputs 0 gives y1 = 12571 and y3 = 3846.
- R6: While `out_valid` is high, every output lies in the range 0 to 16416.
- R7: An input value from 16417 up to 65535 gives the same results as its residue mod 16417.
- R8: `out_valid` on any clock equals `in_valid` on the clock before.
- R9: On a clock where `in_valid` is low, all four outputs keep their previous values.
- R10: While `rst_n` is low, `out_valid` is 0 and all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks the four inputs as a sample set |
| x0 | input | 16 | Sample at offset 0 |
| x1 | input | 16 | Sample at offset N/4 |
| x2 | input | 16 | Sample at offset N/2 |
| x3 | input | 16 | Sample at offset 3N/4 |
| out_valid | output | 1 | Results valid, one clock after `in_valid` |
| y0 | output | 16 | Sum of all four inputs |
| y1 | output | 16 | Combination with -J on x1 and +J on x3 |
| y2 | output | 16 | Alternating-sign combination |
| y3 | output | 16 | Combination with +J on x1 and -J on x3 |

## Verification
A single non-zero input on `x1` or on `x3` shows where J enters and with which sign, so it separates y1 from y3. The all-zero and all-16416 sets probe the lower and upper edges of the modular add and subtract. Sets built from values at or above 16417, including 65535, check the input folding. Long random streams of residues and raw 16-bit words, with `in_valid` toggled at random, are compared on every clock. These streams separate a correct update from a missed hold or a valid flag in the wrong cycle.

// File: rtl/ntt_radix4_butterfly.sv
module ntt_radix4_butterfly #(
  parameter int W       = 16,
  parameter int MODULUS = 16417,
  parameter int ROOT4   = 3846
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] x0,
  input  logic [W-1:0] x1,
  input  logic [W-1:0] x2,
  input  logic [W-1:0] x3,
  output logic         out_valid,
  output logic [W-1:0] y0,
  output logic [W-1:0] y1,
  output logic [W-1:0] y2,
  output logic [W-1:0] y3
);

  localparam int CW    = $clog2(ROOT4 + 1);
  localparam int PW    = W + CW;
  localparam int FOLDS = ((1 << W) - 1) / MODULUS;
  localparam logic [W:0]    PM = (W+1)'(MODULUS);
  localparam logic [PW-1:0] PP = PW'(MODULUS);
  localparam logic [PW-1:0] JC = PW'(ROOT4);

  function automatic logic [W-1:0] fold(input logic [W-1:0] v);
    logic [W:0] t;
    t = {1'b0, v};
    for (int i = 0; i < FOLDS; i++)
      if (t >= PM) t = t - PM;
    return t[W-1:0];
  endfunction

  function automatic logic [W-1:0] madd(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= PM) s = s - PM;
    return s[W-1:0];
  endfunction

  function automatic logic [W-1:0] msub(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    if (a >= b) s = {1'b0, a} - {1'b0, b};
    else        s = {1'b0, a} + PM - {1'b0, b};
    return s[W-1:0];
  endfunction

  function automatic logic [W-1:0] mulj(input logic [W-1:0] a);
    logic [PW-1:0] p;
    p = PW'(a) * JC;
    p = p % PP;
    return p[W-1:0];
  endfunction

  logic [W-1:0] r [4];
  logic [W-1:0] raw [4];
  assign raw[0] = x0;
  assign raw[1] = x1;
  assign raw[2] = x2;
  assign raw[3] = x3;

  for (genvar g = 0; g < 4; g++) begin : g_fold
    assign r[g] = fold(raw[g]);
  end

  logic [W-1:0] jb, jd, s02, d02, s13, dj;
  assign jb  = mulj(r[1]);
  assign jd  = mulj(r[3]);
  assign s02 = madd(r[0], r[2]);
  assign d02 = msub(r[0], r[2]);
  assign s13 = madd(r[1], r[3]);
  assign dj  = msub(jb, jd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      y0 <= '0;
      y1 <= '0;
      y2 <= '0;
      y3 <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        y0 <= madd(s02, s13);
        y1 <= msub(d02, dj);
        y2 <= msub(s02, s13);
        y3 <= madd(d02, dj);
      end
    end
  end

  assert_sum_all_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(in_valid) |->
      32'(y0) == (32'($past(x0)) + 32'($past(x1)) + 32'($past(x2)) + 32'($past(x3))) % MODULUS);

  assert_neg_j_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(in_valid) |->
      (32'(y1) + ROOT4 * (32'($past(x1)) % MODULUS) + 32'($past(x2))) % MODULUS ==
      (32'($past(x0)) + ROOT4 * (32'($past(x3)) % MODULUS)) % MODULUS);

  assert_alt_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(in_valid) |->
      (32'(y2) + 32'($past(x1)) + 32'($past(x3))) % MODULUS ==
      (32'($past(x0)) + 32'($past(x2))) % MODULUS);

  assert_pos_j_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(in_valid) |->
      (32'(y3) + ROOT4 * (32'($past(x3)) % MODULUS) + 32'($past(x2))) % MODULUS ==
      (32'($past(x0)) + ROOT4 * (32'($past(x1)) % MODULUS)) % MODULUS);

  assert_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(y0) < MODULUS) && (32'(y1) < MODULUS) &&
                  (32'(y2) < MODULUS) && (32'(y3) < MODULUS));

  assert_valid_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(in_valid) |->
      $stable(y0) && $stable(y1) && $stable(y2) && $stable(y3));

endmodule

// File: tb/ntt_radix4_butterfly_test.sv
module ntt_radix4_butterfly_test;
  localparam int P = 16417;
  localparam int J = 3846;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] x0 = '0, x1 = '0, x2 = '0, x3 = '0;
  logic out_valid;
  logic [15:0] y0, y1, y2, y3;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  int exp_y [4];
  int exp_v;
  bit hold_cycle;

  always #4 clk = ~clk;

  ntt_radix4_butterfly uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .x0(x0), .x1(x1), .x2(x2), .x3(x3),
    .out_valid(out_valid), .y0(y0), .y1(y1), .y2(y2), .y3(y3)
  );

  function automatic int md(int v);
    return ((v % P) + P) % P;
  endfunction

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(bit v, int a, int b, int c, int d);
    int ra, rb, rc, rd;
    in_valid = v;
    x0 = 16'(a); x1 = 16'(b); x2 = 16'(c); x3 = 16'(d);
    ra = a % P; rb = b % P; rc = c % P; rd = d % P;
    hold_cycle = !v;
    exp_v = v ? 1 : 0;
    if (v) begin
      exp_y[0] = md(ra + rb + rc + rd);
      exp_y[1] = md(ra - J * rb - rc + J * rd);
      exp_y[2] = md(ra - rb + rc - rd);
      exp_y[3] = md(ra + J * rb - rc - J * rd);
    end
    @(negedge clk);
  endtask

  task automatic compare_all(string note);
    check({"R8 out_valid", note}, int'(out_valid), exp_v);
    if (hold_cycle) begin
      check({"R9 y0 hold", note}, int'(y0), exp_y[0]);
      check({"R9 y1 hold", note}, int'(y1), exp_y[1]);
      check({"R9 y2 hold", note}, int'(y2), exp_y[2]);
      check({"R9 y3 hold", note}, int'(y3), exp_y[3]);
    end else begin
      check({"R1 y0", note}, int'(y0), exp_y[0]);
      check({"R2 y1", note}, int'(y1), exp_y[1]);
      check({"R3 y2", note}, int'(y2), exp_y[2]);
      check({"R4 y3", note}, int'(y3), exp_y[3]);
    end
    if (out_valid)
      check({"R6 range", note},
            int'(y0 < P && y1 < P && y2 < P && y3 < P), 1);
  endtask

  task automatic step(bit v, int a, int b, int c, int d, string note);
    drive(v, a, b, c, d);
    compare_all(note);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) exp_y[k] = 0;
    exp_v = 0;
    hold_cycle = 1'b0;
    in_valid = 1'b1;
    x0 = 16'd5; x1 = 16'd6; x2 = 16'd7; x3 = 16'd8;
    repeat (3) @(negedge clk);
    check("R10 reset out_valid", int'(out_valid), 0);
    check("R10 reset y0", int'(y0), 0);
    check("R10 reset y1", int'(y1), 0);
    check("R10 reset y2", int'(y2), 0);
    check("R10 reset y3", int'(y3), 0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    step(1, 0, 1, 0, 0, " R5 unit x1");
    check("R5 y1 is -J", int'(y1), 12571);
    check("R5 y3 is J", int'(y3), 3846);
    step(1, 0, 0, 0, 1, " R5 unit x3");
    check("R5 y1 is J", int'(y1), 3846);
    step(1, 0, 0, 0, 0, " zeros");
    step(1, P - 1, P - 1, P - 1, P - 1, " top residues");
    step(1, 1, 2, 3, 4, " small ramp");
    step(1, P, P, P, P, " R7 all modulus");
    check("R7 modulus folds to zero", int'(y0), 0);
    step(1, 65535, 65535, 65535, 65535, " R7 all ones");
    step(1, 3 * P + 7, 2 * P + 1, P + 100, 65535, " R7 mixed raw");
    step(0, 11, 22, 33, 44, " R9 idle");
    step(0, 99, 98, 97, 96, " R9 idle again");
    step(1, 9, 8, 7, 6, " resume");

    for (int n = 0; n < 3000; n++) begin
      bit v;
      bit raw;
      v = 1'($urandom_range(0, 3) != 0);
      raw = 1'($urandom_range(0, 1));
      if (raw)
        step(v, int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
             int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)), " R7 random raw");
      else
        step(v, int'($urandom_range(0, P - 1)), int'($urandom_range(0, P - 1)),
             int'($urandom_range(0, P - 1)), int'($urandom_range(0, P - 1)), " random residue");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule